// File: doc/BRIEF.md
# Two-way set-associative write-back cache

This block is a cache controller between a processor request port and a slower block-oriented memory port. Each byte address is cut into a tag, a set index and a byte offset. The two lines of the indexed set are searched in parallel. A hit completes in the cycle it is presented. A miss stalls the processor while the controller moves whole 4-byte blocks over the memory port.

Stores change only the cache and mark the line as modified. A modified line goes back to memory only when it is chosen as a victim, just before the refill that replaces it. Each set keeps a single bit naming its least recently used way, and an empty way is always taken before a valid one is evicted. A store miss first fetches the block, then merges the byte into it. The address is 24 bits with a 2-bit offset. The set width is the parameter `SET_W`: 13 gives the full 9/13/2 split, and the default of 8 keeps the arrays small.

Top module: `cache2w_wb`

## Requirements
- R1: The set index is `cpu_addr[SET_W+1:2]`, the tag is `cpu_addr[23:SET_W+2]`, and the offset `cpu_addr[1:0]` selects byte k of a block, held at bits 8k+7:8k. The memory block address is `{tag,set}` (`cpu_addr[23:2]`).
- R2: After reset every line is invalid. `mem_req` is low. The first access of any address misses.
- R3: A request that hits raises `cpu_ready` in the same cycle, with `cpu_rdata` set to the addressed byte, and starts no memory transaction.
- R4: A read miss holds `cpu_ready` low and issues one memory read of the block. In the cycle after the read is acknowledged, the held request hits and returns the byte taken from the fetched block.
- R5: A write hit changes only the addressed byte of the line and marks that line dirty. No memory transaction occurs, and later reads return the written byte.
- R6: When the victim line is valid and dirty, its block is written to memory at its own block address (`mem_we`=1), with its current data, before the new block is read.
- R7: When the victim line is clean, no memory write occurs and only the refill read is issued.
- R8: When both ways are valid, the victim is the way not used most recently. Every hit or fill to a way makes the other way the next victim.
- R9: On a miss to a set with an invalid way, the invalid way is filled, with way 0 taken first. No valid line is evicted.
- R10: A write miss fetches the block, merges the byte into it and leaves the line dirty, so evicting that line later writes back the merged block.
- R11: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high.
- R12: At most one way of the indexed set ever matches the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held with its address and data until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte store, 0 = byte load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block writeback, 0 = block read |
| mem_addr | output | 22 | Block address |
| mem_wdata | output | 32 | Writeback block data |
| mem_rdata | input | 32 | Read block data, taken when `mem_ack` is high |
| mem_ack | input | 1 | Memory transaction completes this cycle |

## Verification
On every cycle the assertions check that the memory request stays stable until it is acknowledged, that a writeback is always followed by a refill read, and that a completed refill makes the held request hit. They also check that a store hit leaves its line dirty and that the two ways of a set never match together. Victim choice cannot be seen in a single cycle. Nor can the order of writeback and refill, the skipping of a writeback for a clean line, or the survival of merged store data through eviction and re-fetch. Only the bench's scripted sequences on one set show these: they fill the empty ways, touch the ways in a chosen order, and then evict.

// File: rtl/cache2w_wb.sv
module cache2w_wb #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = ADDR_W - SET_W - 2;
  localparam int SETS  = 1 << SET_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [TAG_W-1:0] tag_m [2][SETS];
  logic [31:0]      dat_m [2][SETS];
  logic [SETS-1:0]  vld [2];
  logic [SETS-1:0]  dty [2];
  logic [SETS-1:0]  lru;
  logic             vic;

  logic [SET_W-1:0] set;
  logic [TAG_W-1:0] tg;
  logic [1:0]       off;
  logic             h0, h1, hit, hway, vsel;
  logic [31:0]      line, mline;

  assign set  = cpu_addr[SET_W+1:2];
  assign tg   = cpu_addr[ADDR_W-1:SET_W+2];
  assign off  = cpu_addr[1:0];
  assign h0   = vld[0][set] && (tag_m[0][set] == tg);
  assign h1   = vld[1][set] && (tag_m[1][set] == tg);
  assign hit  = h0 | h1;
  assign hway = h1;
  assign line = hway ? dat_m[1][set] : dat_m[0][set];
  assign vsel = !vld[0][set] ? 1'b0 : (!vld[1][set] ? 1'b1 : lru[set]);

  always_comb begin
    mline = line;
    mline[{off, 3'b000} +: 8] = cpu_wdata;
  end

  assign cpu_rdata = line[{off, 3'b000} +: 8];
  assign cpu_ready = (st == S_IDLE) && cpu_req && hit;
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_m[vic][set], set} : {tg, set};
  assign mem_wdata = dat_m[vic][set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vld[0] <= '0;
      vld[1] <= '0;
      dty[0] <= '0;
      dty[1] <= '0;
      lru    <= '0;
      vic    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (hit) begin
            lru[set] <= ~hway;
            if (cpu_we) begin
              dat_m[hway][set] <= mline;
              dty[hway][set]   <= 1'b1;
            end
          end else begin
            vic <= vsel;
            st  <= (vld[vsel][set] && dty[vsel][set]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) st <= S_FILL;
        S_FILL: if (mem_ack) begin
          dat_m[vic][set] <= mem_rdata;
          tag_m[vic][set] <= tg;
          vld[vic][set]   <= 1'b1;
          dty[vic][set]   <= 1'b0;
          lru[set]        <= ~vic;
          st              <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && cpu_req |=> cpu_ready);

  // R5
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |=> dty[$past(hway)][$past(set)]);

  // R12
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h0, h1}));
endmodule

// File: tb/sim_cache2w_wb.sv
module sim_cache2w_wb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        cpu_ready, mem_req, mem_we, mem_ack = 0;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  cache2w_wb #(.ADDR_W(24), .SET_W(SW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cnt = 0;
  logic [31:0] mm [int];
  logic [31:0] gold [int];
  logic [54:0] exp_mem [$];
  logic [7:0]  exp_rd [$];
  string       exp_tag [$];
  string       rd_tag [$];

  function automatic logic [31:0] init_blk(logic [21:0] ba);
    return 32'hC0DE0000 ^ {10'h0, ba} ^ {ba[7:0], 24'h0};
  endfunction
  function automatic logic [31:0] gblk(logic [21:0] ba);
    return gold.exists(int'(ba)) ? gold[int'(ba)] : init_blk(ba);
  endfunction
  function automatic logic [23:0] mk(int t, int s, int o);
    return {t[13:0], s[SW-1:0], o[1:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory responder
  always @(posedge clk) begin
    #1;
    if (mem_ack) begin
      mem_ack = 0;
      cnt = 0;
    end else if (mem_req) begin
      cnt++;
      if (cnt == 2) begin
        if (mem_we) mm[int'(mem_addr)] = mem_wdata;
        else mem_rdata = mm.exists(int'(mem_addr)) ? mm[int'(mem_addr)] : init_blk(mem_addr);
        mem_ack = 1;
      end
    end
  end

  // monitor: memory transactions and load results
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_mem.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual unexpected mem txn we=%b addr=%h expected none", mem_we, mem_addr);
      end else begin
        logic [54:0] e;
        string t;
        e = exp_mem.pop_front();
        t = exp_tag.pop_front();
        chk(t, {mem_we, mem_addr}, {e[54], e[53:32]});
        if (mem_we) chk(t, mem_wdata, e[31:0]);
      end
    end
    if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
      if (exp_rd.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 actual unexpected read expected none");
      end else chk(rd_tag.pop_front(), cpu_rdata, exp_rd.pop_front());
    end
  end

  task automatic exp_fill(logic [21:0] ba, string t);
    exp_mem.push_back({1'b0, ba, 32'h0});
    exp_tag.push_back(t);
  endtask
  task automatic exp_wb(logic [21:0] ba, string t);
    exp_mem.push_back({1'b1, ba, gblk(ba)});
    exp_tag.push_back(t);
  endtask

  task automatic access(logic we, logic [23:0] a, logic [7:0] d, string t);
    logic [31:0] b;
    int guard;
    b = gblk(a[23:2]);
    if (!we) begin
      exp_rd.push_back(b[{a[1:0], 3'b000} +: 8]);
      rd_tag.push_back(t);
    end
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    guard = 0;
    @(negedge clk);
    while (!cpu_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 200) begin
      checks++; errors++;
      $display("FAIL %s actual timeout expected ready", t);
    end
    if (we) begin
      b[{a[1:0], 3'b000} +: 8] = d;
      gold[int'(a[23:2])] = b;
    end
    @(posedge clk); #1;
    cpu_req = 0;
    chk({t, " queue"}, exp_mem.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R2 mem_req", mem_req, 0);
    chk("R2 ready", cpu_ready, 0);
    // R2 R4 R9 R1: cold miss fills way 0
    exp_fill(mk(1, 5, 1) >> 2, "R4");
    access(0, mk(1, 5, 1), 0, "R4");
    access(0, mk(1, 5, 3), 0, "R3");
    // R9: second way empty, filled without eviction
    exp_fill(mk(2, 5, 0) >> 2, "R9");
    access(0, mk(2, 5, 0), 0, "R9");
    access(0, mk(1, 5, 0), 0, "R8");
    // R5: store hit, no memory traffic
    access(1, mk(1, 5, 2), 8'h77, "R5");
    // R8 R7: LRU victim is tag 2 (clean), only refill
    exp_fill(mk(3, 5, 0) >> 2, "R7");
    access(0, mk(3, 5, 0), 0, "R7");
    access(0, mk(1, 5, 2), 0, "R5");
    access(0, mk(3, 5, 1), 0, "R8");
    // R6: victim tag 1 dirty, written back then refill
    exp_wb(mk(1, 5, 0) >> 2, "R6");
    exp_fill(mk(4, 5, 0) >> 2, "R6");
    access(0, mk(4, 5, 3), 0, "R6");
    // R1: another set untouched by set 5 traffic
    exp_fill(mk(4, 6, 0) >> 2, "R1");
    access(0, mk(4, 6, 2), 0, "R1");
    access(0, mk(3, 5, 2), 0, "R1");
    // R10: write miss allocates and merges
    exp_fill(mk(5, 9, 0) >> 2, "R10");
    access(1, mk(5, 9, 0), 8'h99, "R10");
    access(0, mk(5, 9, 0), 0, "R10");
    exp_fill(mk(6, 9, 0) >> 2, "R9");
    access(0, mk(6, 9, 1), 0, "R9");
    exp_wb(mk(5, 9, 0) >> 2, "R10");
    exp_fill(mk(7, 9, 0) >> 2, "R10");
    access(0, mk(7, 9, 0), 0, "R10");
    exp_fill(mk(5, 9, 0) >> 2, "R10");
    access(0, mk(5, 9, 0), 0, "R10");
    repeat (4) @(posedge clk);
    chk("R11 idle", mem_req, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule